// File: doc/BRIEF.md
# PCIe DMA Request Splitter

This block accepts one DMA transfer descriptor (a source address, a destination address, a byte length and a direction) and turns it into a series of bus sub-requests. Every sub-request obeys the PCI Express size and boundary rules. For a read, the sub-requests target the source address. For a write, they target the destination address. Each sub-request is offered on a valid/ready handshake and carries the following fields:

- the host address;
- a byte length;
- the number of data beats for the configured datapath width;
- its byte offset within the transfer;
- for reads, a tag.

The offset lets the local side place or fetch the data that belongs to each piece.

A sub-request's length is the least of three values: the bytes still to send, the size limit for its direction, and the distance to the next 4 KB page edge. Read sub-requests draw a tag from a small free pool, so that completions that come back out of order can be matched. The block records the byte offset under each tag. Completion logic can look up a tag's offset and return the tag to the pool. When every tag is in use, read issue stalls. A single-cycle done pulse closes each transfer.

Top module: `xfer_splitter`

## Requirements
- R1: No sub-request spans a 4096-byte address page: req_addr[11:0] + req_len never exceeds 4096, and a piece that would cross a page edge is cut at that edge.
- R2: A write sub-request is no longer than the write size limit. The limit is set by the 3-bit code on cfg_wr_size_code: code n in 0..5 means 128 << n bytes, and codes 6 and 7 mean 4096 bytes.
- R3: A read sub-request is no longer than the read size limit, decoded from cfg_rd_size_code with the same 3-bit encoding as R2.
- R4: Each sub-request length is min(remaining bytes, direction limit, 4096 - (address mod 4096)). Consecutive sub-requests are contiguous. req_offset is the number of bytes issued before the sub-request, and the lengths add up to the descriptor length.
- R5: req_beats equals ceil(req_len / (DATA_W/8)), which is 32-byte beats at the default DATA_W of 256.
- R6: A read sub-request carries the lowest-numbered free tag at the time it first becomes valid. That tag stays busy until cpl_release is asserted with it on cpl_tag. cpl_offset returns the req_offset recorded for the tag on cpl_tag. While all NUM_TAGS tags are busy, req_valid stays low for a pending read.
- R7: desc_ready is high only while the block is idle. A descriptor offered while busy is ignored. Both size codes are sampled when a descriptor is accepted, and later changes do not affect the transfer in progress.
- R8: done is high for exactly one cycle: the cycle that follows the handshake of the final sub-request.
- R9: A descriptor whose length is zero produces no sub-request, and done is high in the cycle after acceptance.
- R10: The two low bits of the addresses and of the length are ignored (treated as zero), so every req_addr and req_len is a multiple of 4.
- R11: While req_valid is high and req_ready is low, req_valid stays high and req_addr, req_len, req_beats, req_tag, req_offset and req_is_rd hold their values into the next cycle.
- R12: A write sub-request has req_is_rd low and req_tag zero, and it takes no tag from the pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block idle, descriptor can be taken |
| desc_src_addr | input | ADDR_W | Transfer source address |
| desc_dst_addr | input | ADDR_W | Transfer destination address |
| desc_len | input | LEN_W | Transfer length in bytes |
| desc_is_rd | input | 1 | 1 = read from host (uses source), 0 = write to host (uses destination) |
| cfg_wr_size_code | input | 3 | Write payload size code |
| cfg_rd_size_code | input | 3 | Read request size code |
| req_valid | output | 1 | Sub-request offered |
| req_ready | input | 1 | Sub-request taken downstream |
| req_addr | output | ADDR_W | Sub-request host address |
| req_len | output | 13 | Sub-request length in bytes (4 to 4096) |
| req_beats | output | BEAT_W | Data beats in the sub-request |
| req_is_rd | output | 1 | Sub-request is a read |
| req_tag | output | TAG_W | Read tag, zero for writes |
| req_offset | output | LEN_W | Byte offset of the sub-request within the transfer |
| cpl_tag | input | TAG_W | Tag to look up or release |
| cpl_offset | output | LEN_W | Recorded offset of cpl_tag |
| cpl_release | input | 1 | Return cpl_tag to the free pool |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The bench places transfers so that the page edge, the size limit and the remaining count each set the length of some piece. This includes a first piece that is only 64 or 128 bytes before an edge and a short tail. A design that applies the page cut in the wrong order would emit a piece straddling 4 KB, or lengths that do not add up. It also fills the tag pool, checks that issue stalls, and releases tags out of order. A design that reuses a busy tag, picks a tag other than the lowest free one, or records the wrong offset under a tag shows a wrong tag or lookup value. Other runs cover zero-length and sub-dword descriptors, unaligned addresses, size codes 6 and 7, and descriptors and code changes offered mid-transfer. In those runs, a design with an off-by-one done pulse, a spurious request, or a limit taken from live configuration fails on done, on req_valid or on req_len.

// File: rtl/xs_pkg.sv
package xs_pkg;

    localparam int unsigned PAGE_BYTES = 4096;
    localparam int unsigned PAGE_SH    = 12;
    localparam int unsigned SUB_W      = 13;

    typedef enum logic {
        XS_IDLE  = 1'b0,
        XS_ISSUE = 1'b1
    } xs_state_e;

    // 3-bit size code to a byte limit; codes above 5 saturate at one page
    function automatic logic [SUB_W-1:0] size_code_bytes(input logic [2:0] code);
        logic [SUB_W-1:0] b;
        case (code)
            3'd0:    b = 13'd128;
            3'd1:    b = 13'd256;
            3'd2:    b = 13'd512;
            3'd3:    b = 13'd1024;
            3'd4:    b = 13'd2048;
            default: b = 13'd4096;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/xs_len_calc.sv
module xs_len_calc
    import xs_pkg::*;
#(
    parameter int LEN_W  = 24,
    parameter int DATA_W = 256,
    localparam int BEAT_BYTES = DATA_W / 8,
    localparam int BEAT_SH    = $clog2(BEAT_BYTES),
    localparam int BEAT_W     = $clog2(PAGE_BYTES / BEAT_BYTES) + 1
) (
    input  logic [PAGE_SH-1:0] page_off,
    input  logic [LEN_W-1:0]   rem_len,
    input  logic [2:0]         size_code,
    output logic [SUB_W-1:0]   chunk_len,
    output logic [BEAT_W-1:0]  chunk_beats,
    output logic               chunk_last
);

    logic [SUB_W-1:0] lim_bytes;
    logic [SUB_W-1:0] to_page;
    logic [SUB_W-1:0] rem_cap;
    logic [SUB_W-1:0] len_c;

    always_comb begin
        lim_bytes = size_code_bytes(size_code);
        to_page   = SUB_W'(PAGE_BYTES) - {1'b0, page_off};
        rem_cap   = (rem_len > LEN_W'(PAGE_BYTES)) ? SUB_W'(PAGE_BYTES) : rem_len[SUB_W-1:0];
        len_c     = rem_cap;
        if (lim_bytes < len_c) len_c = lim_bytes;
        if (to_page < len_c)   len_c = to_page;
    end

    assign chunk_len   = len_c;
    assign chunk_beats = BEAT_W'((len_c + SUB_W'(BEAT_BYTES - 1)) >> BEAT_SH);
    assign chunk_last  = (rem_len == LEN_W'(len_c));

endmodule

// File: rtl/xs_tag_pool.sv
module xs_tag_pool #(
    parameter int NUM_TAGS = 8,
    parameter int OFF_W    = 24,
    localparam int TAG_W   = $clog2(NUM_TAGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic [TAG_W-1:0] alloc_id,
    input  logic [OFF_W-1:0] alloc_off,
    input  logic             rel_en,
    input  logic [TAG_W-1:0] rel_id,
    input  logic [TAG_W-1:0] lkp_id,
    output logic [OFF_W-1:0] lkp_off,
    output logic             any_free,
    output logic [TAG_W-1:0] free_id
);

    typedef struct packed {
        logic [NUM_TAGS-1:0] busy;
    } pool_t;

    pool_t pool_d, pool_q;
    logic [NUM_TAGS-1:0][OFF_W-1:0] off_all;

    // lowest-numbered free entry
    always_comb begin
        free_id = '0;
        for (int i = NUM_TAGS - 1; i >= 0; i--) begin
            if (!pool_q.busy[i]) free_id = TAG_W'(i);
        end
        any_free = ~&pool_q.busy;
    end

    always_comb begin
        pool_d = pool_q;
        if (rel_en)   pool_d.busy[rel_id]   = 1'b0;
        if (alloc_en) pool_d.busy[alloc_id] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pool_q <= '0;
        else        pool_q <= pool_d;
    end

    for (genvar g = 0; g < NUM_TAGS; g++) begin : g_off
        logic [OFF_W-1:0] ent_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_q <= '0;
            else if (alloc_en && alloc_id == TAG_W'(g))
                ent_q <= alloc_off;
        end
        assign off_all[g] = ent_q;
    end

    assign lkp_off = off_all[lkp_id];

    AST_ALLOC_FREE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !pool_q.busy[alloc_id]); // R6
    AST_ALLOC_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> pool_q.busy[$past(alloc_id)]); // R6

endmodule

// File: rtl/xfer_splitter.sv
module xfer_splitter
    import xs_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int LEN_W    = 24,
    parameter int DATA_W   = 256,
    parameter int NUM_TAGS = 8,
    localparam int TAG_W   = $clog2(NUM_TAGS),
    localparam int BEAT_W  = $clog2(PAGE_BYTES / (DATA_W / 8)) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic [ADDR_W-1:0] desc_src_addr,
    input  logic [ADDR_W-1:0] desc_dst_addr,
    input  logic [LEN_W-1:0]  desc_len,
    input  logic              desc_is_rd,
    input  logic [2:0]        cfg_wr_size_code,
    input  logic [2:0]        cfg_rd_size_code,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [SUB_W-1:0]  req_len,
    output logic [BEAT_W-1:0] req_beats,
    output logic              req_is_rd,
    output logic [TAG_W-1:0]  req_tag,
    output logic [LEN_W-1:0]  req_offset,
    input  logic [TAG_W-1:0]  cpl_tag,
    output logic [LEN_W-1:0]  cpl_offset,
    input  logic              cpl_release,
    output logic              done
);

    typedef struct packed {
        xs_state_e         st;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  rem;
        logic [LEN_W-1:0]  off;
        logic              rd;
        logic [2:0]        code;
        logic              tag_lk;
        logic [TAG_W-1:0]  tag_id;
        logic              done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [SUB_W-1:0]  chunk_len;
    logic [BEAT_W-1:0] chunk_beats;
    logic              chunk_last;
    logic              any_free;
    logic [TAG_W-1:0]  free_id;
    logic [TAG_W-1:0]  cur_tag;
    logic              fire;
    logic [LEN_W-1:0]  len_al;
    logic [ADDR_W-1:0] addr_al;

    xs_len_calc #(
        .LEN_W  (LEN_W),
        .DATA_W (DATA_W)
    ) u_len (
        .page_off    (ctl_q.addr[PAGE_SH-1:0]),
        .rem_len     (ctl_q.rem),
        .size_code   (ctl_q.code),
        .chunk_len   (chunk_len),
        .chunk_beats (chunk_beats),
        .chunk_last  (chunk_last)
    );

    xs_tag_pool #(
        .NUM_TAGS (NUM_TAGS),
        .OFF_W    (LEN_W)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (fire && ctl_q.rd),
        .alloc_id  (cur_tag),
        .alloc_off (ctl_q.off),
        .rel_en    (cpl_release),
        .rel_id    (cpl_tag),
        .lkp_id    (cpl_tag),
        .lkp_off   (cpl_offset),
        .any_free  (any_free),
        .free_id   (free_id)
    );

    // tag shown on a stalled read is frozen so a release cannot change it
    assign cur_tag   = ctl_q.tag_lk ? ctl_q.tag_id : free_id;
    assign req_valid = (ctl_q.st == XS_ISSUE) && (!ctl_q.rd || ctl_q.tag_lk || any_free);
    assign fire      = req_valid && req_ready;

    assign desc_ready = (ctl_q.st == XS_IDLE);
    assign req_addr   = ctl_q.addr;
    assign req_len    = chunk_len;
    assign req_beats  = chunk_beats;
    assign req_is_rd  = ctl_q.rd;
    assign req_tag    = ctl_q.rd ? cur_tag : '0;
    assign req_offset = ctl_q.off;
    assign done       = ctl_q.done;

    assign len_al  = {desc_len[LEN_W-1:2], 2'b00};
    assign addr_al = desc_is_rd ? {desc_src_addr[ADDR_W-1:2], 2'b00}
                                : {desc_dst_addr[ADDR_W-1:2], 2'b00};

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        case (ctl_q.st)
            XS_IDLE: begin
                if (desc_valid) begin
                    ctl_d.rd     = desc_is_rd;
                    ctl_d.addr   = addr_al;
                    ctl_d.rem    = len_al;
                    ctl_d.off    = '0;
                    ctl_d.code   = desc_is_rd ? cfg_rd_size_code : cfg_wr_size_code;
                    ctl_d.tag_lk = 1'b0;
                    if (len_al == '0) ctl_d.done = 1'b1;
                    else              ctl_d.st   = XS_ISSUE;
                end
            end
            XS_ISSUE: begin
                if (fire) begin
                    ctl_d.addr   = ctl_q.addr + ADDR_W'(chunk_len);
                    ctl_d.rem    = ctl_q.rem - LEN_W'(chunk_len);
                    ctl_d.off    = ctl_q.off + LEN_W'(chunk_len);
                    ctl_d.tag_lk = 1'b0;
                    if (chunk_last) begin
                        ctl_d.st   = XS_IDLE;
                        ctl_d.done = 1'b1;
                    end
                end else if (req_valid && ctl_q.rd && !ctl_q.tag_lk) begin
                    ctl_d.tag_lk = 1'b1;
                    ctl_d.tag_id = free_id;
                end
            end
            default: ctl_d.st = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= XS_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ({1'b0, req_addr[PAGE_SH-1:0]} + req_len) <= SUB_W'(PAGE_BYTES)); // R1
    AST_WR_SIZE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_rd) |-> req_len <= size_code_bytes(ctl_q.code)); // R2
    AST_RD_SIZE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_rd) |-> req_len <= size_code_bytes(ctl_q.code)); // R3
    AST_LEN_WITHIN_REM: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len != '0) && (LEN_W'(req_len) <= ctl_q.rem)); // R4
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !desc_ready); // R7
    AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid); // R8
    AST_DWORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[1:0] == 2'b00) && (req_len[1:0] == 2'b00)); // R10
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> req_valid && $stable(req_addr) && $stable(req_len)
            && $stable(req_tag) && $stable(req_offset) && $stable(req_beats)
            && $stable(req_is_rd)); // R11
    AST_WR_TAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_rd) |-> req_tag == '0); // R12

endmodule

// File: tb/xfer_splitter_bench.sv
module xfer_splitter_bench;

    localparam int ADDR_W   = 64;
    localparam int LEN_W    = 24;
    localparam int DATA_W   = 256;
    localparam int NUM_TAGS = 8;
    localparam int TAG_W    = $clog2(NUM_TAGS);
    localparam int BEAT_B   = DATA_W / 8;
    localparam int BEAT_W   = $clog2(4096 / BEAT_B) + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              desc_valid = 1'b0;
    logic              desc_ready;
    logic [ADDR_W-1:0] desc_src_addr = '0;
    logic [ADDR_W-1:0] desc_dst_addr = '0;
    logic [LEN_W-1:0]  desc_len = '0;
    logic              desc_is_rd = 1'b0;
    logic [2:0]        cfg_wr_size_code = '0;
    logic [2:0]        cfg_rd_size_code = '0;
    logic              req_valid;
    logic              req_ready = 1'b0;
    logic [ADDR_W-1:0] req_addr;
    logic [12:0]       req_len;
    logic [BEAT_W-1:0] req_beats;
    logic              req_is_rd;
    logic [TAG_W-1:0]  req_tag;
    logic [LEN_W-1:0]  req_offset;
    logic [TAG_W-1:0]  cpl_tag = '0;
    logic [LEN_W-1:0]  cpl_offset;
    logic              cpl_release = 1'b0;
    logic              done;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    xfer_splitter u_xfer_splitter (
        .clk(clk), .rst_n(rst_n),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_src_addr(desc_src_addr), .desc_dst_addr(desc_dst_addr),
        .desc_len(desc_len), .desc_is_rd(desc_is_rd),
        .cfg_wr_size_code(cfg_wr_size_code), .cfg_rd_size_code(cfg_rd_size_code),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_beats(req_beats),
        .req_is_rd(req_is_rd), .req_tag(req_tag), .req_offset(req_offset),
        .cpl_tag(cpl_tag), .cpl_offset(cpl_offset), .cpl_release(cpl_release),
        .done(done)
    );

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, expv);
        end
    endtask

    function automatic logic [63:0] lim_of(input logic [2:0] code);
        return (code > 3'd5) ? 64'd4096 : (64'd128 << code);
    endfunction

    function automatic logic [63:0] exp_chunk(input logic [63:0] a, input logic [63:0] rem,
                                              input logic [63:0] lim);
        logic [63:0] c;
        logic [63:0] pg;
        c  = (rem > 64'd4096) ? 64'd4096 : rem;
        if (lim < c) c = lim;
        pg = 64'd4096 - (a % 64'd4096);
        if (pg < c) c = pg;
        return c;
    endfunction

    task automatic release_tags(input int n);
        for (int t = 0; t < n; t++) begin
            @(negedge clk);
            cpl_tag     = TAG_W'(t);
            cpl_release = 1'b1;
        end
        @(negedge clk);
        cpl_release = 1'b0;
    endtask

    task automatic offer_desc(input logic [63:0] src, input logic [63:0] dst,
                              input logic [23:0] len, input logic rd,
                              input logic [2:0] wcode, input logic [2:0] rcode);
        @(negedge clk);
        chk("R7 desc_ready when idle", 64'(desc_ready), 64'd1);
        desc_src_addr    = src;
        desc_dst_addr    = dst;
        desc_len         = len;
        desc_is_rd       = rd;
        cfg_wr_size_code = wcode;
        cfg_rd_size_code = rcode;
        desc_valid       = 1'b1;
        @(negedge clk);
        desc_valid = 1'b0;
    endtask

    // generic scenario: full expected sequence from the length rule
    task automatic run_xfer(input logic [63:0] src, input logic [63:0] dst,
                            input logic [23:0] len, input logic rd,
                            input logic [2:0] code, input logic stall);
        logic [63:0] a, rem, lim, off, c;
        logic [63:0] h_addr, h_len, h_off;
        int idx, cyc;
        bit have_prev, rdy;
        logic [2:0] other;
        other = (code == 3'd0) ? 3'd5 : 3'd0;
        a    = (rd ? src : dst) & ~64'd3;
        rem  = 64'(len) & ~64'd3;
        lim  = lim_of(code);
        off  = 0;
        idx  = 0;
        cyc  = 0;
        have_prev = 0;
        h_addr = 0; h_len = 0; h_off = 0;
        offer_desc(src, dst, len, rd, rd ? other : code, rd ? code : other);
        if (rem == 0) begin
            chk("R9 zero length done next cycle", 64'(done), 64'd1);
            chk("R9 zero length no request", 64'(req_valid), 64'd0);
            @(negedge clk);
            chk("R9 zero length done single cycle", 64'(done), 64'd0);
            chk("R9 zero length still no request", 64'(req_valid), 64'd0);
            return;
        end
        while (rem != 0 && cyc < 2000) begin
            rdy = stall ? ((cyc % 3) != 2) : 1'b1;
            req_ready = rdy;
            chk("R4 request offered", 64'(req_valid), 64'd1);
            chk("R8 done low mid transfer", 64'(done), 64'd0);
            if (req_valid) begin
                c = exp_chunk(a, rem, lim);
                if (have_prev) begin
                    chk("R11 addr held", req_addr, h_addr);
                    chk("R11 len held", 64'(req_len), h_len);
                    chk("R11 offset held", 64'(req_offset), h_off);
                end
                chk("R4 addr", req_addr, a);
                chk("R4 len", 64'(req_len), c);
                chk("R4 offset", 64'(req_offset), off);
                chk("R5 beats", 64'(req_beats), (c + BEAT_B - 1) / BEAT_B);
                chk("R12 direction", 64'(req_is_rd), 64'(rd));
                chk(rd ? "R6 tag" : "R12 write tag zero", 64'(req_tag), rd ? 64'(idx) : 64'd0);
                chk("R1 page", ((a % 4096) + c <= 4096) ? 64'd1 : 64'd0, 64'd1);
                chk(rd ? "R3 read limit" : "R2 write limit", (c <= lim) ? 64'd1 : 64'd0, 64'd1);
                chk("R7 busy not ready", 64'(desc_ready), 64'd0);
                if (rdy) begin
                    a = a + c; rem = rem - c; off = off + c; idx++;
                    have_prev = 0;
                end else begin
                    have_prev = 1;
                    h_addr = req_addr; h_len = 64'(req_len); h_off = 64'(req_offset);
                end
            end
            @(negedge clk);
            cyc++;
        end
        req_ready = 1'b0;
        chk("R8 done after last", 64'(done), 64'd1);
        chk("R8 no request after last", 64'(req_valid), 64'd0);
        @(negedge clk);
        chk("R8 done single cycle", 64'(done), 64'd0);
        if (rd) release_tags(idx);
    endtask

    task automatic test_tag_pool;
        offer_desc(64'h0, 64'h5000, 24'd1280, 1'b1, 3'd0, 3'd0);
        req_ready = 1'b1;
        for (int i = 0; i < NUM_TAGS; i++) begin
            chk("R6 read offered while tags free", 64'(req_valid), 64'd1);
            chk("R6 tag in order", 64'(req_tag), 64'(i));
            chk("R4 offset in pool test", 64'(req_offset), 64'(128 * i));
            @(negedge clk);
        end
        chk("R6 stall when no tag free", 64'(req_valid), 64'd0);
        cpl_tag = 3'd3;
        #1;
        chk("R6 offset lookup tag3", 64'(cpl_offset), 64'd384);
        @(negedge clk);
        chk("R6 still stalled", 64'(req_valid), 64'd0);
        cpl_tag = 3'd5; cpl_release = 1'b1;
        @(negedge clk);
        cpl_release = 1'b0;
        chk("R6 resumes after release", 64'(req_valid), 64'd1);
        chk("R6 released tag reused", 64'(req_tag), 64'd5);
        chk("R4 addr after stall", req_addr, 64'd1024);
        chk("R4 offset after stall", 64'(req_offset), 64'd1024);
        @(negedge clk);
        chk("R6 stall again", 64'(req_valid), 64'd0);
        cpl_tag = 3'd5;
        #1;
        chk("R6 offset lookup reused tag5", 64'(cpl_offset), 64'd1024);
        cpl_tag = 3'd2; cpl_release = 1'b1;
        @(negedge clk);
        cpl_release = 1'b0;
        chk("R6 lowest free tag", 64'(req_tag), 64'd2);
        chk("R4 last piece len", 64'(req_len), 64'd128);
        @(negedge clk);
        chk("R8 done after pool test", 64'(done), 64'd1);
        req_ready = 1'b0;
        release_tags(NUM_TAGS);
    endtask

    task automatic test_busy_ignore;
        offer_desc(64'h0, 64'h4000, 24'd512, 1'b0, 3'd0, 3'd0);
        req_ready = 1'b1;
        cfg_wr_size_code = 3'd5;
        desc_dst_addr    = 64'h9000;
        desc_len         = 24'd64;
        desc_valid       = 1'b1;
        for (int i = 0; i < 4; i++) begin
            chk("R7 desc_ready low while busy", 64'(desc_ready), 64'd0);
            chk("R7 addr unaffected", req_addr, 64'h4000 + 64'(128 * i));
            chk("R7 code sampled at accept", 64'(req_len), 64'd128);
            if (i == 3) desc_valid = 1'b0;
            @(negedge clk);
        end
        chk("R8 done busy test", 64'(done), 64'd1);
        req_ready = 1'b0;
        @(negedge clk);
        chk("R7 ignored descriptor left no request", 64'(req_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 reset done low", 64'(done), 64'd0);
        chk("R4 reset no request", 64'(req_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 reset idle ready", 64'(desc_ready), 64'd1);
        // write, page cut first then 512-byte limit, tail
        run_xfer(64'h0, 64'h1000_0FC0, 24'd10000, 1'b0, 3'd2, 1'b0);
        // read with backpressure, page cut then 1024 limit
        run_xfer(64'h2_0F80, 64'h0, 24'd3000, 1'b1, 3'd3, 1'b1);
        // codes 7 and 6 saturate at 4096
        run_xfer(64'h0, 64'h0, 24'd9000, 1'b0, 3'd7, 1'b0);
        run_xfer(64'h800, 64'h0, 24'd5000, 1'b1, 3'd6, 1'b1);
        // R10 unaligned addr and length
        run_xfer(64'h0, 64'h0FC3, 24'h203, 1'b0, 3'd2, 1'b0);
        // R9 zero and sub-dword length
        run_xfer(64'h100, 64'h200, 24'd0, 1'b0, 3'd1, 1'b0);
        run_xfer(64'h100, 64'h200, 24'd3, 1'b1, 3'd1, 1'b0);
        test_tag_pool();
        test_busy_ignore();
        // small write at code 0 after the pool test
        run_xfer(64'h0, 64'h7F00, 24'd600, 1'b0, 3'd0, 1'b1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule